// File: doc/BRIEF.md
# SEC-DED Hamming Codec

This block pairs an encoder and a decoder for a single-error-correcting Hamming code. The code carries one extra overall parity bit, so double errors are also detected. With the default of four check bits, eleven data bits become a sixteen-bit codeword. The encoder places the data, computes the check bits and appends the parity bit. The decoder forms a syndrome from the received word. That syndrome points straight at a flipped bit, which the decoder inverts. When the error cannot be repaired, the decoder raises a flag instead.

The two paths are independent and each has its own valid qualifier. A typical use puts the encoder in front of a storage array or link and the decoder behind it. Both paths register their results, so each answers one clock after its input. The valid bit travels alongside the result.

Top module: `secded_codec`

## Requirements
- R1: Codeword index 0 holds the overall parity bit. Check bit j sits at index 2^j, which is 1, 2, 4 and 8. Data bit i sits at the i-th index that is not a power of two, counted upward from 3: data bit 0 at 3, bit 1 at 5, and on through bit 10 at 15. Check bit j is the XOR of the data bits whose index has bit j set.
- R2: Every codeword the encoder emits has an even number of ones across all sixteen bits.
- R3: Each path answers one cycle after its input. Its output valid equals its input valid from the previous cycle. The encoder output holds its last value while its input valid is low.
- R4: A received word that is a valid codeword returns its data with both error flags low.
- R5: A word with a single flipped bit at any index from 1 to 15 returns the original data, with the single-error flag high and the double-error flag low.
- R6: A word whose only flipped bit is index 0 returns its data unchanged, with the single-error flag high.
- R7: A word with two flipped bits raises the double-error flag and keeps the single-error flag low. The data output then holds the bits at the data indices of the received word, with no correction applied.
- R8: While the decoder input valid is low, both flags output low one cycle later and the data output keeps its last value.
- R9: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Encoder input qualifier |
| enc_data_i | input | 11 | Data to encode |
| enc_valid_o | output | 1 | Encoder result qualifier |
| enc_code_o | output | 16 | Encoded word |
| dec_valid_i | input | 1 | Decoder input qualifier |
| dec_code_i | input | 16 | Received word |
| dec_valid_o | output | 1 | Decoder result qualifier |
| dec_data_o | output | 11 | Recovered data |
| dec_sec_o | output | 1 | A single error was found and repaired |
| dec_ded_o | output | 1 | A double error was found but not repaired |

## Verification
The encoder is driven with a walking one, all zeros, all ones and random words. The walking one ties each data bit to its index and to the check bits it feeds, while the random words exercise the parity across many check combinations. The decoder receives clean words, every one of the sixteen single flips, and random pairs of distinct flips. These three groups separate the no-error, repaired and detect-only outcomes, and the flip at index 0 isolates the parity-only case. Idle cycles on the decoder, fed with garbage, confirm that the flags drop and the data holds.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int MAX_W = 64;

  typedef enum logic [1:0] {
    DEC_CLEAN  = 2'd0,
    DEC_PARITY = 2'd1,
    DEC_DOUBLE = 2'd2,
    DEC_SINGLE = 2'd3
  } dec_class_e;

  function automatic bit is_pow2(int p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

  // index in the codeword of data bit idx
  function automatic int data_pos(int idx, int m);
    int cnt;
    cnt = 0;
    for (int p = 1; p < (1 << m); p++) begin
      if (!is_pow2(p)) begin
        if (cnt == idx) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  // data bit number held at codeword index p (p not a power of two)
  function automatic int data_idx(int p);
    int cnt;
    cnt = 0;
    for (int q = 1; q < p; q++) if (!is_pow2(q)) cnt++;
    return cnt;
  endfunction

  // indices 1..2^m-1 with bit j set; with_chk keeps the check index itself
  function automatic logic [MAX_W-1:0] cover_mask(int j, int m, bit with_chk);
    logic [MAX_W-1:0] msk;
    msk = '0;
    for (int p = 1; p < (1 << m); p++) begin
      if (((p >> j) & 1) != 0 && (with_chk || !is_pow2(p))) msk[p] = 1'b1;
    end
    return msk;
  endfunction
endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome #(
  parameter int M = 4,
  parameter int N = 2 ** M
) (
  input  logic [N-1:0] code_i,
  output logic [M-1:0] syn_o,
  output logic         par_odd_o
);
  import secded_pkg::*;

  // recomputed check XOR received check: mask includes the check index
  for (genvar j = 0; j < M; j++) begin : g_syn
    localparam logic [MAX_W-1:0] MSK = cover_mask(j, M, 1'b1);
    assign syn_o[j] = ^(code_i & MSK[N-1:0]);
  end

  assign par_odd_o = ^code_i;
endmodule

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int M = 4,
  parameter int N = 2 ** M,
  parameter int K = N - 1 - M
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [K-1:0] data_i,
  output logic         valid_o,
  output logic [N-1:0] code_o
);
  import secded_pkg::*;

  logic [N-1:0] placed;
  logic [M-1:0] chk;
  logic [N-1:0] code_d;

  for (genvar p = 0; p < N; p++) begin : g_place
    if (p == 0 || is_pow2(p)) begin : g_gap
      assign placed[p] = 1'b0;
    end else begin : g_dat
      localparam int DI = data_idx(p);
      assign placed[p] = data_i[DI];
    end
  end

  for (genvar j = 0; j < M; j++) begin : g_chk
    localparam logic [MAX_W-1:0] MSK = cover_mask(j, M, 1'b0);
    assign chk[j] = ^(placed & MSK[N-1:0]);
  end

  always_comb begin
    code_d = placed;
    for (int j = 0; j < M; j++) code_d[1 << j] = chk[j];
    code_d[0] = ^code_d[N-1:1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) code_o <= code_d;
    end
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int M = 4,
  parameter int N = 2 ** M,
  parameter int K = N - 1 - M
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [N-1:0] code_i,
  output logic         valid_o,
  output logic [K-1:0] data_o,
  output logic         sec_o,
  output logic         ded_o
);
  import secded_pkg::*;

  logic [M-1:0] syn;
  logic         par_odd;
  dec_class_e   cls;
  logic [N-1:0] fixed;
  logic [K-1:0] data_d;

  secded_syndrome #(.M(M), .N(N)) u_syn (
    .code_i   (code_i),
    .syn_o    (syn),
    .par_odd_o(par_odd)
  );

  always_comb begin
    unique case ({syn != '0, par_odd})
      2'b00:   cls = DEC_CLEAN;
      2'b01:   cls = DEC_PARITY;
      2'b10:   cls = DEC_DOUBLE;
      default: cls = DEC_SINGLE;
    endcase
  end

  // syndrome is the index of the flipped bit
  always_comb begin
    fixed = code_i;
    if (cls == DEC_SINGLE) fixed[syn] = ~code_i[syn];
  end

  for (genvar i = 0; i < K; i++) begin : g_ext
    localparam int P = data_pos(i, M);
    assign data_d[i] = fixed[P];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      sec_o   <= 1'b0;
      ded_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      sec_o   <= valid_i && (cls == DEC_SINGLE || cls == DEC_PARITY);
      ded_o   <= valid_i && (cls == DEC_DOUBLE);
      if (valid_i) data_o <= data_d;
    end
  end
endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
  parameter int M_BITS = 4,
  localparam int N_BITS = 2 ** M_BITS,
  localparam int K_BITS = N_BITS - 1 - M_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_valid_i,
  input  logic [K_BITS-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [N_BITS-1:0] enc_code_o,
  input  logic              dec_valid_i,
  input  logic [N_BITS-1:0] dec_code_i,
  output logic              dec_valid_o,
  output logic [K_BITS-1:0] dec_data_o,
  output logic              dec_sec_o,
  output logic              dec_ded_o
);
  secded_enc #(.M(M_BITS), .N(N_BITS), .K(K_BITS)) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(enc_valid_i),
    .data_i (enc_data_i),
    .valid_o(enc_valid_o),
    .code_o (enc_code_o)
  );

  secded_dec #(.M(M_BITS), .N(N_BITS), .K(K_BITS)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(dec_valid_i),
    .code_i (dec_code_i),
    .valid_o(dec_valid_o),
    .data_o (dec_data_o),
    .sec_o  (dec_sec_o),
    .ded_o  (dec_ded_o)
  );
endmodule

// File: rtl/secded_chk.sv
module secded_chk #(
  parameter int M_BITS = 4,
  localparam int N_BITS = 2 ** M_BITS,
  localparam int K_BITS = N_BITS - 1 - M_BITS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enc_valid_i,
  input logic [K_BITS-1:0] enc_data_i,
  input logic              enc_valid_o,
  input logic [N_BITS-1:0] enc_code_o,
  input logic              dec_valid_i,
  input logic [N_BITS-1:0] dec_code_i,
  input logic              dec_valid_o,
  input logic [K_BITS-1:0] dec_data_o,
  input logic              dec_sec_o,
  input logic              dec_ded_o
);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  AST_ENC_EVEN_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_o |-> (^enc_code_o) == 1'b0); // R2

  AST_ENC_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    enc_valid_o == $past(enc_valid_i)); // R3

  AST_DEC_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    dec_valid_o == $past(dec_valid_i)); // R3

  AST_ENC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !$past(enc_valid_i) |-> $stable(enc_code_o)); // R3

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_sec_o && dec_ded_o)); // R7

  AST_FLAGS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o |-> (!dec_sec_o && !dec_ded_o)); // R8

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !$past(dec_valid_i) |-> $stable(dec_data_o)); // R8
endmodule

bind secded_codec secded_chk #(.M_BITS(M_BITS)) u_chk (.*);

// File: tb/secded_codec_tb_top.sv
`timescale 1ns/1ps
module secded_codec_tb_top;
  localparam int N = 16;
  localparam int K = 11;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         enc_valid_i, dec_valid_i;
  logic [K-1:0] enc_data_i;
  logic [N-1:0] dec_code_i;
  logic         enc_valid_o, dec_valid_o, dec_sec_o, dec_ded_o;
  logic [N-1:0] enc_code_o;
  logic [K-1:0] dec_data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [N-1:0] exp_code = '0;
  logic [K-1:0] exp_data = '0;

  always #4 clk_i = ~clk_i;

  secded_codec dut_i (.*);

  function automatic bit pw2(int p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

  function automatic logic [N-1:0] ref_enc(logic [K-1:0] d);
    logic [N-1:0] w;
    int n;
    w = '0;
    n = 0;
    for (int p = 1; p < N; p++) if (!pw2(p)) begin w[p] = d[n]; n++; end
    for (int j = 0; j < 4; j++) begin
      logic b;
      b = 1'b0;
      for (int q = 1; q < N; q++) if (!pw2(q) && ((q >> j) & 1) == 1) b = b ^ w[q];
      w[1 << j] = b;
    end
    w[0] = ^w[N-1:1];
    return w;
  endfunction

  function automatic logic [K-1:0] ref_ext(logic [N-1:0] w);
    logic [K-1:0] d;
    int n;
    n = 0;
    for (int p = 1; p < N; p++) if (!pw2(p)) begin d[n] = w[p]; n++; end
    return d;
  endfunction

  // brute force: find the single flip (if any) that yields a valid codeword
  function automatic void ref_dec(input logic [N-1:0] w, output logic [K-1:0] d,
                                  output logic s, output logic e);
    s = 1'b0; e = 1'b0; d = ref_ext(w);
    if (ref_enc(ref_ext(w)) == w) return;
    for (int k = 0; k < N; k++) begin
      logic [N-1:0] f;
      f = w;
      f[k] = ~f[k];
      if (ref_enc(ref_ext(f)) == f) begin
        s = 1'b1; d = ref_ext(f); return;
      end
    end
    e = 1'b1;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(logic ev, logic [K-1:0] ed, string etag,
                     logic dv, logic [N-1:0] dc, string dtag);
    logic [K-1:0] xd;
    logic xs, xe;
    enc_valid_i = ev; enc_data_i = ed;
    dec_valid_i = dv; dec_code_i = dc;
    if (ev) exp_code = ref_enc(ed);
    ref_dec(dc, xd, xs, xe);
    if (dv) exp_data = xd;
    else begin xs = 1'b0; xe = 1'b0; end
    @(negedge clk_i);
    chk(enc_valid_o == ev, "R3", "enc_valid", 32'(enc_valid_o), 32'(ev));
    chk(enc_code_o == exp_code, etag, "enc_code", 32'(enc_code_o), 32'(exp_code));
    if (ev) chk((^enc_code_o) == 1'b0, "R2", "parity", 32'(^enc_code_o), 0);
    chk(dec_valid_o == dv, "R3", "dec_valid", 32'(dec_valid_o), 32'(dv));
    chk(dec_data_o == exp_data, dtag, "dec_data", 32'(dec_data_o), 32'(exp_data));
    chk(dec_sec_o == xs, dtag, "sec", 32'(dec_sec_o), 32'(xs));
    chk(dec_ded_o == xe, dtag, "ded", 32'(dec_ded_o), 32'(xe));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    enc_valid_i = 1'b0; enc_data_i = '0;
    dec_valid_i = 1'b0; dec_code_i = '0;
    repeat (3) @(negedge clk_i);
    enc_valid_i = 1'b1; enc_data_i = '1;
    dec_valid_i = 1'b1; dec_code_i = '1;
    @(negedge clk_i);
    // R9 outputs stay zero under reset even with active inputs
    chk(enc_valid_o == 1'b0, "R9", "enc_valid", 32'(enc_valid_o), 0);
    chk(enc_code_o == '0, "R9", "enc_code", 32'(enc_code_o), 0);
    chk(dec_valid_o == 1'b0, "R9", "dec_valid", 32'(dec_valid_o), 0);
    chk(dec_data_o == '0, "R9", "dec_data", 32'(dec_data_o), 0);
    chk(dec_sec_o == 1'b0, "R9", "sec", 32'(dec_sec_o), 0);
    chk(dec_ded_o == 1'b0, "R9", "ded", 32'(dec_ded_o), 0);
    enc_valid_i = 1'b0; dec_valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 walking one, zeros, ones; decoder idle with garbage (R8)
    for (int i = 0; i < K; i++)
      cyc(1'b1, K'(1) << i, "R1", 1'b0, N'($urandom), "R8");
    cyc(1'b1, '0, "R1", 1'b0, N'($urandom), "R8");
    cyc(1'b1, '1, "R1", 1'b0, N'($urandom), "R8");

    // R4 clean words straight from the reference encoder
    for (int i = 0; i < 40; i++) begin
      logic [K-1:0] d;
      d = K'($urandom);
      cyc(1'b1, K'($urandom), "R1", 1'b1, ref_enc(d), "R4");
    end

    // R5 and R6: every single flip; encoder idle so its output holds (R3)
    for (int t = 0; t < 6; t++) begin
      logic [N-1:0] w;
      w = ref_enc(K'($urandom));
      for (int k = 0; k < N; k++) begin
        logic [N-1:0] f;
        f = w;
        f[k] = ~f[k];
        cyc(1'b0, K'($urandom), "R3", 1'b1, f, (k == 0) ? "R6" : "R5");
      end
    end

    // R7 two distinct flips
    for (int t = 0; t < 120; t++) begin
      logic [N-1:0] f;
      int a, b;
      f = ref_enc(K'($urandom));
      a = $urandom_range(0, N - 1);
      b = (a + 1 + $urandom_range(0, N - 2)) % N;
      f[a] = ~f[a];
      f[b] = ~f[b];
      cyc(t[0], K'($urandom), "R3", 1'b1, f, "R7");
    end

    // R8 idle after a double error: flags drop, data holds
    for (int i = 0; i < 4; i++)
      cyc(1'b0, K'($urandom), "R3", 1'b0, N'($urandom), "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule